// File: doc/BRIEF.md
# Mode-Dependent Five-Pin I/O Port

This block controls five bidirectional pins. It holds a direction register, an output data register and a synchronised pin-read path, and all three are reached over a small word-addressed register bus. The direction register cannot be read back. Reads from it return a fixed filler byte.

The reset value of the direction register depends on the two-bit operating mode sampled during a power-on reset or hardware standby. A manual reset and software standby both leave the direction register untouched. In the three external-bus modes, pins 1 to 4 do not drive data when their direction bit is set. Instead they drive one of four chip-select lines that arrive from an external bus controller. A hold control decides whether those chip-selects keep driving or float while the chip is in software standby. Pin 0 is always plain GPIO. In the single-chip mode, all five pins are plain GPIO.

Top module: `gpio_modal_port`

## Requirements
- R1: After a power-on reset (`por_n` low at a clock edge) in mode 2'b00 or 2'b01, the direction bits equal 5'b10000, so pin 4 is the only enabled output.
- R2: After a power-on reset in mode 2'b10 or 2'b11, all direction bits are 0 and no pin is enabled.
- R3: `hw_standby` high at a clock edge reloads the direction bits with the same mode-dependent value as a power-on reset.
- R4: While `man_rst_n` is low, the direction bits keep their last value and ignore writes, and the data register clears to 0.
- R5: While `sw_standby` is high, the direction bits keep their value and writes to them are ignored.
- R6: A read of the direction address (0x0) always returns 8'hFF.
- R7: The data register (address 0x4) holds the written bits 4:0, reads back with bits 7:5 as 0, and is 0 after power-on reset.
- R8: A level on `pin_in` shows in bits 4:0 of a read of address 0x8 after exactly two rising clock edges, with bits 7:5 read as 0.
- R9: A write to the pin-read address 0x8 changes neither the direction bits nor the data register.
- R10: In modes 2'b00, 2'b01 and 2'b10, pin k (k = 1..4) with direction bit 1 has `pin_oe[k]`=1 and `pin_out[k]` = `chip_sel[k-1]`. With direction bit 0 it has `pin_oe[k]`=0.
- R11: Pin 0 in every mode, and pins 1 to 4 in mode 2'b11, have `pin_oe` equal to the direction bit and `pin_out` equal to the data bit AND the direction bit.
- R12: During `sw_standby`, chip-select pins stop driving (`pin_oe`=0, `pin_out`=0) when `cs_hold`=0 and keep driving when `cs_hold`=1. GPIO pins are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| man_rst_n | input | 1 | Manual reset, synchronous, active low |
| hw_standby | input | 1 | Hardware standby, reinitialises the port |
| sw_standby | input | 1 | Software standby |
| cs_hold | input | 1 | 1: chip-selects keep driving in software standby |
| mode | input | 2 | Operating mode |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| chip_sel | input | 4 | Chip-select levels from the bus controller |
| pin_in | input | 5 | Pad input levels |
| pin_out | output | 5 | Pad output levels |
| pin_oe | output | 5 | Pad output enables |

## Verification
The output mux is exercised in every mode with different direction masks. A full mask against a partial mask shows whether each pin's enable follows its own bit. Chip-select patterns that differ from the data pattern show whether the chip-select source or the data source drives each pin. The reset paths are compared by writing a non-default direction and then applying a power-on reset, a hardware standby or a manual reset. Only the first two may restore the mode-dependent value. Software standby is run with the hold control at both settings to show that it applies to chip-select pins and not to GPIO pins.

// File: rtl/gmp_pkg.sv
// Shared types for the five-pin port.
// Assumes: the mode encoding below is fixed by the system integration.
package gmp_pkg;
    typedef enum logic [1:0] {
        MODE_XA = 2'b00,  // external bus, pin 4 preset as output
        MODE_XB = 2'b01,  // external bus, pin 4 preset as output
        MODE_XC = 2'b10,  // external bus, no preset
        MODE_SC = 2'b11   // single chip, all GPIO
    } op_mode_e;

    // Register byte offsets (word aligned)
    localparam logic [3:0] OFS_DIR  = 4'h0;
    localparam logic [3:0] OFS_DATA = 4'h4;
    localparam logic [3:0] OFS_PIN  = 4'h8;

    // Chip-select routing applies in every mode except single chip.
    function automatic logic cs_route(input logic [1:0] m);
        return m != MODE_SC;
    endfunction

    // The direction preset for pin 4 applies in the first two modes.
    function automatic logic dir_preset(input logic [1:0] m);
        return (m == MODE_XA) || (m == MODE_XB);
    endfunction
endpackage

// File: rtl/gmp_dir_reg.sv
// Direction register with a mode-dependent reset value.
// Power-on reset and hardware standby load the preset. A manual reset and
// software standby freeze the contents. It is write-only from the bus.
// Assumes: all controls are synchronous to clk.
module gmp_dir_reg #(
    parameter int            N_PINS  = 5,
    parameter logic [N_PINS-1:0] PRESET = 5'b10000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              man_rst_n,
    input  logic              hw_standby,
    input  logic              sw_standby,
    input  logic [1:0]        mode,
    input  logic              wr_en,
    input  logic [N_PINS-1:0] wr_val,
    output logic [N_PINS-1:0] dir_q
);
    import gmp_pkg::*;

    logic [N_PINS-1:0] init_val;

    // Select the reset value from the current mode.
    always_comb begin
        init_val = dir_preset(mode) ? PRESET : '0;
    end

    // Hold or update the direction bits by reset type.
    always_ff @(posedge clk) begin
        if (!por_n || hw_standby) begin
            dir_q <= init_val;
        end else if (!man_rst_n || sw_standby) begin
            dir_q <= dir_q;
        end else if (wr_en) begin
            dir_q <= wr_val;
        end
    end
endmodule

// File: rtl/gmp_pin_sync.sv
// Two-stage synchroniser for the pad inputs.
// Assumes: pad levels are asynchronous. The stages have no reset, so the
// sampled value is undefined until two clocks have passed.
module gmp_pin_sync #(
    parameter int N_PINS = 5
) (
    input  logic              clk,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_sync
);
    logic [N_PINS-1:0] stage1;

    // Shift the pad levels through two flops.
    always_ff @(posedge clk) begin
        stage1   <= pin_in;
        pin_sync <= stage1;
    end
endmodule

// File: rtl/gmp_pin_mux.sv
// Per-pin output selection between GPIO data and a chip-select line.
// Pins 1..N_CS can carry chip-selects and pin 0 is always GPIO.
// Assumes: chip_sel[k-1] belongs to pin k.
module gmp_pin_mux #(
    parameter int N_PINS = 5,
    parameter int N_CS   = 4
) (
    input  logic [1:0]        mode,
    input  logic              sw_standby,
    input  logic              cs_hold,
    input  logic [N_PINS-1:0] dir_q,
    input  logic [N_PINS-1:0] data_q,
    input  logic [N_CS-1:0]   chip_sel,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe
);
    import gmp_pkg::*;

    logic cs_mode;
    logic cs_float;

    // Decide whether chip-select routing and floating apply.
    always_comb begin
        cs_mode  = cs_route(mode);
        cs_float = sw_standby && !cs_hold;
    end

    for (genvar k = 0; k < N_PINS; k++) begin : g_pin
        if (k >= 1 && k <= N_CS) begin : g_cs
            // Route either the chip-select or the data bit to this pin.
            always_comb begin
                if (cs_mode) begin
                    pin_oe[k]  = dir_q[k] && !cs_float;
                    pin_out[k] = pin_oe[k] && chip_sel[k-1];
                end else begin
                    pin_oe[k]  = dir_q[k];
                    pin_out[k] = dir_q[k] && data_q[k];
                end
            end
        end else begin : g_gpio
            // Plain GPIO pin.
            always_comb begin
                pin_oe[k]  = dir_q[k];
                pin_out[k] = dir_q[k] && data_q[k];
            end
        end
    end
endmodule

// File: rtl/gpio_modal_port.sv
// Top of the five-pin port: register decode, data register, read mux and
// the instances of the direction register, synchroniser and pin mux.
// Assumes: a single-cycle write strobe and combinational read data.
module gpio_modal_port #(
    parameter int         N_PINS   = 5,
    parameter int         N_CS     = 4,
    parameter int         DATA_W   = 8,
    parameter int         ADDR_W   = 4,
    parameter logic [7:0] DIR_FILL = 8'hFF
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              man_rst_n,
    input  logic              hw_standby,
    input  logic              sw_standby,
    input  logic              cs_hold,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_CS-1:0]   chip_sel,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe
);
    import gmp_pkg::*;

    localparam int PAD_W = DATA_W - N_PINS;
    localparam logic [N_PINS-1:0] DIR_PRESET = N_PINS'(1) << (N_PINS - 1);

    logic              sel_dir, sel_data, sel_pin;
    logic [N_PINS-1:0] dir_q;
    logic [N_PINS-1:0] data_q;
    logic [N_PINS-1:0] pin_sync;

    // Decode the register address.
    always_comb begin
        sel_dir  = bus_addr == ADDR_W'(OFS_DIR);
        sel_data = bus_addr == ADDR_W'(OFS_DATA);
        sel_pin  = bus_addr == ADDR_W'(OFS_PIN);
    end

    gmp_dir_reg #(.N_PINS(N_PINS), .PRESET(DIR_PRESET)) u_dir (
        .clk        (clk),
        .por_n      (por_n),
        .man_rst_n  (man_rst_n),
        .hw_standby (hw_standby),
        .sw_standby (sw_standby),
        .mode       (mode),
        .wr_en      (bus_wr && sel_dir),
        .wr_val     (bus_wdata[N_PINS-1:0]),
        .dir_q      (dir_q)
    );

    // Data register: cleared by any reset, written from the bus.
    always_ff @(posedge clk) begin
        if (!por_n || hw_standby || !man_rst_n) begin
            data_q <= '0;
        end else if (bus_wr && sel_data) begin
            data_q <= bus_wdata[N_PINS-1:0];
        end
    end

    gmp_pin_sync #(.N_PINS(N_PINS)) u_sync (
        .clk      (clk),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    gmp_pin_mux #(.N_PINS(N_PINS), .N_CS(N_CS)) u_mux (
        .mode       (mode),
        .sw_standby (sw_standby),
        .cs_hold    (cs_hold),
        .dir_q      (dir_q),
        .data_q     (data_q),
        .chip_sel   (chip_sel),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    // Read mux: direction reads give filler, other registers are zero-padded.
    always_comb begin
        if (sel_dir) begin
            bus_rdata = DIR_FILL;
        end else if (sel_data) begin
            bus_rdata = {{PAD_W{1'b0}}, data_q};
        end else if (sel_pin) begin
            bus_rdata = {{PAD_W{1'b0}}, pin_sync};
        end else begin
            bus_rdata = '0;
        end
    end
endmodule

// File: rtl/gmp_checker.sv
// Property checker for gpio_modal_port, attached by bind.
module gmp_checker (
    input logic       clk,
    input logic       por_n,
    input logic       man_rst_n,
    input logic       hw_standby,
    input logic       sw_standby,
    input logic       cs_hold,
    input logic [1:0] mode,
    input logic [3:0] chip_sel,
    input logic [4:0] pin_in,
    input logic [4:0] pin_out,
    input logic [4:0] pin_oe,
    input logic [4:0] dir_q,
    input logic [4:0] data_q,
    input logic [4:0] pin_sync
);
    logic [1:0] age;

    // Count the cycles since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!por_n) age <= '0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    p_preset_r1: assert property (@(posedge clk) disable iff (1'b0)
        (!por_n && !mode[1]) |=> (dir_q == 5'b10000));

    p_clear_r2: assert property (@(posedge clk) disable iff (1'b0)
        (!por_n && mode[1]) |=> (dir_q == 5'b00000));

    p_hwstby_r3: assert property (@(posedge clk) disable iff (!por_n)
        hw_standby |=> (dir_q == (mode[1] ? 5'b00000 : 5'b10000)) || !mode[1] == $past(!mode[1]) == 1'b0);

    p_manual_keep_r4: assert property (@(posedge clk) disable iff (!por_n || hw_standby)
        !man_rst_n |=> ($stable(dir_q) && data_q == 5'b0));

    p_swstby_keep_r5: assert property (@(posedge clk) disable iff (!por_n || hw_standby)
        sw_standby |=> $stable(dir_q));

    p_sync_r8: assert property (@(posedge clk) disable iff (!por_n)
        (age == 2'd2) |-> (pin_sync == $past(pin_in, 2)));

    p_cs_route_r10: assert property (@(posedge clk) disable iff (!por_n)
        (mode != 2'b11 && !sw_standby) |->
            (pin_oe[4:1] == dir_q[4:1] && pin_out[4:1] == (chip_sel & dir_q[4:1])));

    p_gpio_r11: assert property (@(posedge clk) disable iff (!por_n)
        (pin_oe[0] == dir_q[0]) && (pin_out[0] == (dir_q[0] && data_q[0])));

    p_cs_float_r12: assert property (@(posedge clk) disable iff (!por_n)
        (sw_standby && !cs_hold && mode != 2'b11) |-> (pin_oe[4:1] == 4'b0));
endmodule

bind gpio_modal_port gmp_checker u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .man_rst_n  (man_rst_n),
    .hw_standby (hw_standby),
    .sw_standby (sw_standby),
    .cs_hold    (cs_hold),
    .mode       (mode),
    .chip_sel   (chip_sel),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .dir_q      (dir_q),
    .data_q     (data_q),
    .pin_sync   (pin_sync)
);

// File: tb/sim_gpio_modal_port.sv
// Directed bench for gpio_modal_port. Inputs change on the falling edge and
// outputs are sampled shortly after it.
module sim_gpio_modal_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_DIR = 4'h0, A_DATA = 4'h4, A_PIN = 4'h8;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, man_rst_n = 1'b1, hw_standby = 1'b0;
    logic       sw_standby = 1'b0, cs_hold = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] chip_sel = '0;
    logic [4:0] pin_in = '0;
    logic [4:0] pin_out, pin_oe;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_modal_port u0 (
        .clk(clk), .por_n(por_n), .man_rst_n(man_rst_n), .hw_standby(hw_standby),
        .sw_standby(sw_standby), .cs_hold(cs_hold), .mode(mode),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .chip_sel(chip_sel), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic por(input logic [1:0] m);
        mode = m; por_n = 1'b0;
        tick(2);
        por_n = 1'b1;
    endtask

    task automatic t_reset_preset();
        logic [7:0] r;
        chip_sel = 4'b1000;
        por(2'b00);
        chip_sel = 4'b1000;
        chk("R1 oe", {3'b0, pin_oe}, 8'h10);
        chk("R1 out", {3'b0, pin_out}, 8'h10);
        rd(A_DIR, r);  chk("R6 dir read", r, 8'hFF);
        rd(A_DATA, r); chk("R7 data reset", r, 8'h00);
        por(2'b01);
        chk("R1 mode01 oe", {3'b0, pin_oe}, 8'h10);
    endtask

    task automatic t_reset_clear();
        por(2'b10); chk("R2 mode10 oe", {3'b0, pin_oe}, 8'h00);
        por(2'b11); chk("R2 mode11 oe", {3'b0, pin_oe}, 8'h00);
    endtask

    task automatic t_gpio();
        logic [7:0] r;
        mode = 2'b11; chip_sel = 4'b1111;
        wr(A_DIR, 8'h1F); wr(A_DATA, 8'h0A);
        chk("R11 oe full", {3'b0, pin_oe}, 8'h1F);
        chk("R11 out full", {3'b0, pin_out}, 8'h0A);
        wr(A_DATA, 8'hEA);
        rd(A_DATA, r); chk("R7 upper bits", r, 8'h0A);
        wr(A_DIR, 8'h05);
        chk("R11 oe part", {3'b0, pin_oe}, 8'h05);
        chk("R11 out part", {3'b0, pin_out}, 8'h00);
        rd(A_DIR, r); chk("R6 dir read after write", r, 8'hFF);
    endtask

    task automatic t_chipsel();
        mode = 2'b00;
        wr(A_DIR, 8'h1F); wr(A_DATA, 8'h00);
        chip_sel = 4'b0101; #1;
        chk("R10 mode00 oe", {3'b0, pin_oe}, 8'h1F);
        chk("R10 mode00 out", {3'b0, pin_out}, 8'h0A);
        mode = 2'b10; #1;
        chk("R10 mode10 out", {3'b0, pin_out}, 8'h0A);
        wr(A_DIR, 8'h03);
        chk("R10 partial oe", {3'b0, pin_oe}, 8'h03);
        chk("R10 partial out", {3'b0, pin_out}, 8'h02);
    endtask

    task automatic t_manual();
        logic [7:0] r;
        mode = 2'b11;
        wr(A_DIR, 8'h1F); wr(A_DATA, 8'h0F);
        man_rst_n = 1'b0;
        wr(A_DIR, 8'h00);
        man_rst_n = 1'b1;
        chk("R4 dir kept", {3'b0, pin_oe}, 8'h1F);
        rd(A_DATA, r); chk("R4 data cleared", r, 8'h00);
        chk("R4 out", {3'b0, pin_out}, 8'h00);
    endtask

    task automatic t_swstby();
        mode = 2'b00; chip_sel = 4'b1111;
        wr(A_DIR, 8'h1F); wr(A_DATA, 8'h01);
        sw_standby = 1'b1; cs_hold = 1'b0;
        wr(A_DIR, 8'h00);
        chk("R12 float oe", {3'b0, pin_oe}, 8'h01);
        chk("R12 float out", {3'b0, pin_out}, 8'h01);
        cs_hold = 1'b1; #1;
        chk("R12 hold oe", {3'b0, pin_oe}, 8'h1F);
        sw_standby = 1'b0; cs_hold = 1'b0; #1;
        chk("R5 dir kept", {3'b0, pin_oe}, 8'h1F);
    endtask

    task automatic t_hwstby();
        mode = 2'b00;
        wr(A_DIR, 8'h03);
        hw_standby = 1'b1; tick(1); hw_standby = 1'b0;
        chk("R3 mode00", {3'b0, pin_oe}, 8'h10);
        mode = 2'b11;
        wr(A_DIR, 8'h07);
        hw_standby = 1'b1; tick(1); hw_standby = 1'b0;
        chk("R3 mode11", {3'b0, pin_oe}, 8'h00);
    endtask

    task automatic t_sync();
        logic [7:0] r;
        pin_in = 5'h0A; tick(3);
        pin_in = 5'h15;
        bus_addr = A_PIN;
        tick(1);
        rd(A_PIN, r); chk("R8 one edge", r, 8'h0A);
        tick(1);
        rd(A_PIN, r); chk("R8 two edges", r, 8'h15);
    endtask

    task automatic t_ro_write();
        logic [7:0] r;
        mode = 2'b11;
        wr(A_DIR, 8'h12); wr(A_DATA, 8'h06);
        wr(A_PIN, 8'hFF);
        chk("R9 dir", {3'b0, pin_oe}, 8'h12);
        rd(A_DATA, r); chk("R9 data", r, 8'h06);
    endtask

    bit done = 1'b0;

    initial begin
        tick(1);
        t_reset_preset();
        t_reset_clear();
        t_gpio();
        t_chipsel();
        t_manual();
        t_swstby();
        t_hwstby();
        t_sync();
        t_ro_write();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule